// File: doc/BRIEF.md
# Multichannel Dematrix and Denormalize Unit

This unit rebuilds five audio channels (left, right, centre, left surround, right surround) from one granule of five transmission channels T0..T4, three samples per channel. A loader pushes each transmission sample into one of five three-entry FIFOs. A start pulse then captures a 3-bit arrangement mode and five per-channel gains. The unit produces fifteen results, one every five cycles.

T0 always carries the compatible left mix L0 = L + C + LS, and T1 carries the compatible right mix R0 = R + C + RS. The mode decides which three channels travel directly on T2, T3 and T4. The two remaining channels must be recovered by subtraction. Every such recovery is flattened ahead of time into a signed sum of T0..T4. Each output is therefore an independent five-step accumulation that never waits on another output of the same granule. One adder stage and one multiplier are shared by all outputs, in a two-stage pipeline.

Top module: `mc_dematrix`

## Requirements
- R1: After reset, out_valid and done are low and all five FIFOs are empty, so a start with no data produces no output.
- R2: While idle, a push with push_sel 0..4 appends push_data to that FIFO if it holds fewer than 3 samples. A push to a full FIFO, with push_sel above 4, or while busy is ignored.
- R3: A start is accepted only when the unit is idle and all five FIFOs hold 3 samples; any other start is ignored. Mode and gain are captured at acceptance.
- R4: Channel arrangement: T0 = L+C+LS and T1 = R+C+RS. T2/T3/T4 carry, by mode: 0: C,LS,RS; 1: L,LS,RS; 2: R,LS,RS; 3: L,R,LS; 4: C,L,RS; 5: C,LS,R; 6: C,L,R; 7: L,R,C. The other two channels are solved from the T0/T1 equations.
- R5: Each weighted channel is the flat signed sum implied by R4; for mode 2 this gives L = T0-T1+T2-T3+T4 and C = T1-T2-T4. The sum is taken over the same sample index, starting from zero and adding T0 through T4 in order. After each addition it saturates to 24-bit signed.
- R6: Each output equals the weighted value times the channel's signed 24-bit gain (2 integer bits, 22 fraction bits). Rounding adds 2^21 and then shifts arithmetically right by 22, and the result saturates to 24-bit signed. The gain for channel c sits at gain[24c+23:24c].
- R7: Outputs come in sample order (the first sample pushed comes first). Within each sample they follow channel order L,R,C,LS,RS, coded on out_chan as 0..4.
- R8: The first out_valid pulse appears on the sixth rising edge after the edge that accepts start. Each following result comes exactly 5 cycles after the previous one, and out_valid is high for one cycle per result.
- R9: done pulses for one cycle, one cycle after the fifteenth result. The FIFOs are empty after a granule, so the next granule needs a full refill.
- R10: A start that arrives while a granule is in progress has no effect: exactly fifteen results are produced, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Write one sample into a FIFO |
| push_sel | input | 3 | Target FIFO (transmission channel 0..4) |
| push_data | input | 24 | Signed sample |
| start | input | 1 | Launch a granule |
| mode | input | 3 | Channel arrangement mode |
| gain | input | 120 | Five signed Q2.22 gains, channel c in bits 24c+23..24c |
| out_valid | output | 1 | Result strobe |
| out_chan | output | 3 | Output channel 0..4 (L,R,C,LS,RS) |
| out_data | output | 24 | Signed result |
| done | output | 1 | Granule complete pulse |

## Verification
The ordering and spacing assertions assume that granules never overlap closer than one result slot. This holds because a new start needs fifteen pushes to refill the FIFOs after the previous granule ends. The assertions also assume that reset is not applied in the middle of a granule. The stimulus always refills the FIFOs with one push per cycle after done and asserts reset only at time zero. Disturbing starts and pushes are issued only while a granule is running, which is exactly the case the unit must ignore. The bench sweeps all eight modes over small, full-range and saturating patterns, and derives its expected sums by solving the two mix equations itself.

// File: rtl/mc_dematrix.sv
module mc_dematrix #(
  parameter int W     = 24,
  parameter int GW    = 24,
  parameter int GFRAC = 22,
  parameter int DEPTH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [2:0]      push_sel,
  input  logic [W-1:0]    push_data,
  input  logic            start,
  input  logic [2:0]      mode,
  input  logic [5*GW-1:0] gain,
  output logic            out_valid,
  output logic [2:0]      out_chan,
  output logic [W-1:0]    out_data,
  output logic            done
);
  localparam int NCH = 5;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int SW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW  = W + GW;
  localparam logic [1:0] Z = 2'b00, P = 2'b01, N = 2'b11;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [PW:0]  HALF = (PW+1)'(1) << (GFRAC - 1);

  // coefficient pairs packed {T4,T3,T2,T1,T0}; outputs 0..4 = L,R,C,LS,RS
  function automatic logic [9:0] cvec(input logic [2:0] m, input logic [2:0] o);
    case ({m, o})
      {3'd0,3'd0}: return {Z,N,N,Z,P};
      {3'd0,3'd1}: return {N,Z,N,P,Z};
      {3'd0,3'd2}: return {Z,Z,P,Z,Z};
      {3'd0,3'd3}: return {Z,P,Z,Z,Z};
      {3'd0,3'd4}: return {P,Z,Z,Z,Z};
      {3'd1,3'd0}: return {Z,Z,P,Z,Z};
      {3'd1,3'd1}: return {N,P,P,P,N};
      {3'd1,3'd2}: return {Z,N,N,Z,P};
      {3'd1,3'd3}: return {Z,P,Z,Z,Z};
      {3'd1,3'd4}: return {P,Z,Z,Z,Z};
      {3'd2,3'd0}: return {P,N,P,N,P};
      {3'd2,3'd1}: return {Z,Z,P,Z,Z};
      {3'd2,3'd2}: return {N,Z,N,P,Z};
      {3'd2,3'd3}: return {Z,P,Z,Z,Z};
      {3'd2,3'd4}: return {P,Z,Z,Z,Z};
      {3'd3,3'd0}: return {Z,Z,P,Z,Z};
      {3'd3,3'd1}: return {Z,P,Z,Z,Z};
      {3'd3,3'd2}: return {N,Z,N,Z,P};
      {3'd3,3'd3}: return {P,Z,Z,Z,Z};
      {3'd3,3'd4}: return {P,N,P,P,N};
      {3'd4,3'd0}: return {Z,P,Z,Z,Z};
      {3'd4,3'd1}: return {N,Z,N,P,Z};
      {3'd4,3'd2}: return {Z,Z,P,Z,Z};
      {3'd4,3'd3}: return {Z,N,N,Z,P};
      {3'd4,3'd4}: return {P,Z,Z,Z,Z};
      {3'd5,3'd0}: return {Z,N,N,Z,P};
      {3'd5,3'd1}: return {P,Z,Z,Z,Z};
      {3'd5,3'd2}: return {Z,Z,P,Z,Z};
      {3'd5,3'd3}: return {Z,P,Z,Z,Z};
      {3'd5,3'd4}: return {N,Z,N,P,Z};
      {3'd6,3'd0}: return {Z,P,Z,Z,Z};
      {3'd6,3'd1}: return {P,Z,Z,Z,Z};
      {3'd6,3'd2}: return {Z,Z,P,Z,Z};
      {3'd6,3'd3}: return {Z,N,N,Z,P};
      {3'd6,3'd4}: return {N,Z,N,P,Z};
      {3'd7,3'd0}: return {Z,Z,P,Z,Z};
      {3'd7,3'd1}: return {Z,P,Z,Z,Z};
      {3'd7,3'd2}: return {P,Z,Z,Z,Z};
      {3'd7,3'd3}: return {N,Z,N,Z,P};
      {3'd7,3'd4}: return {N,N,Z,P,Z};
      default:     return '0;
    endcase
  endfunction

  logic [W-1:0]  fmem [NCH][DEPTH];
  logic [CW-1:0] fcnt [NCH];
  logic [NCH-1:0] full;

  logic          busy;
  logic [SW-1:0] s;
  logic [2:0]    c, t;
  logic [2:0]    mode_r;
  logic signed [GW-1:0] gain_a [NCH];
  logic          go, fin;

  assign go  = start && !busy && (&full);
  assign fin = busy && (s == SW'(DEPTH-1)) && (c == 3'd4) && (t == 3'd4);

  for (genvar i = 0; i < NCH; i++) begin : g_fifo
    assign full[i] = (fcnt[i] == CW'(DEPTH));
    wire wr = !busy && push && (push_sel == 3'(i)) && !full[i];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   fcnt[i] <= '0;
      else if (fin) fcnt[i] <= '0;
      else if (wr)  fcnt[i] <= fcnt[i] + 1'b1;
    always_ff @(posedge clk)
      if (wr) fmem[i][SW'(fcnt[i])] <= push_data;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)  gain_a[i] <= '0;
      else if (go) gain_a[i] <= gain[i*GW +: GW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; s <= '0; c <= '0; t <= '0; mode_r <= '0;
    end else if (!busy) begin
      if (go) begin
        busy <= 1'b1; s <= '0; c <= '0; t <= '0; mode_r <= mode;
      end
    end else if (t == 3'd4) begin
      t <= '0;
      if (c == 3'd4) begin
        c <= '0;
        if (s == SW'(DEPTH-1)) busy <= 1'b0;
        else s <= s + 1'b1;
      end else c <= c + 1'b1;
    end else t <= t + 1'b1;
  end

  // stage 1: one signed term per cycle into a saturating accumulator
  logic [9:0] cv;
  logic [1:0] cf;
  logic signed [W-1:0] smp, acc, acc_n;
  logic signed [W+1:0] sx, term, base, sum;

  assign cv   = cvec(mode_r, c);
  assign cf   = 2'(cv >> {t, 1'b0});
  assign smp  = fmem[t][s];
  assign sx   = {{2{smp[W-1]}}, smp};
  assign term = (cf == P) ? sx : (cf == N) ? -sx : '0;
  assign base = (t == 3'd0) ? '0 : {{2{acc[W-1]}}, acc};
  assign sum  = base + term;
  assign acc_n = (sum[W+1:W-1] == 3'b000 || sum[W+1:W-1] == 3'b111) ? sum[W-1:0]
               : (sum[W+1] ? SMIN : SMAX);

  logic          dm_vld, dm_last;
  logic [2:0]    dm_ch;
  logic signed [W-1:0] dm_sum;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc <= '0; dm_vld <= 1'b0; dm_last <= 1'b0; dm_ch <= '0; dm_sum <= '0;
    end else begin
      if (busy) acc <= acc_n;
      dm_vld <= busy && (t == 3'd4);
      if (busy && t == 3'd4) begin
        dm_sum  <= acc_n;
        dm_ch   <= c;
        dm_last <= fin;
      end
    end

  // stage 2: shared multiplier, round and saturate
  logic signed [PW-1:0] prod;
  logic signed [PW:0]   pr, sh;
  logic [W-1:0]         scaled;

  assign prod   = dm_sum * gain_a[dm_ch];
  assign pr     = $signed({prod[PW-1], prod}) + $signed(HALF);
  assign sh     = pr >>> GFRAC;
  assign scaled = (sh[PW:W-1] == '0 || sh[PW:W-1] == '1) ? sh[W-1:0]
                : (sh[PW] ? SMIN : SMAX);

  logic out_last;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0; out_chan <= '0; out_data <= '0; out_last <= 1'b0; done <= 1'b0;
    end else begin
      out_valid <= dm_vld;
      out_last  <= dm_vld && dm_last;
      done      <= out_last;
      if (dm_vld) begin
        out_chan <= dm_ch;
        out_data <= scaled;
      end
    end

  assert_full_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (&full));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_chan_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid, 5) && $past(out_chan, 5) != 3'd4)
      |-> out_chan == $past(out_chan, 5) + 3'd1);

  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_valid) && $past(out_chan) == 3'd4));

endmodule

// File: tb/sim_mc_dematrix.sv
`timescale 1ns/1ps
module sim_mc_dematrix;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, push, start, out_valid, done;
  logic [2:0] push_sel, mode, out_chan;
  logic [23:0] push_data, out_data;
  logic [119:0] gain;

  mc_dematrix u0 (.clk, .rst_n, .push, .push_sel, .push_data, .start, .mode, .gain,
                  .out_valid, .out_chan, .out_data, .done);

  int checks = 0, errors = 0, cyc = 0;
  int tv [5][3];
  int gv [5];
  int cf [8][5][5];
  int unsigned seed = 32'h1234_5678;

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R8 watchdog act=%0d exp=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string rq, bit ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  function automatic int rnd24();
    seed = seed * 1103515245 + 12345;
    return int'($signed(seed[31:8]));
  endfunction

  function automatic longint sat24(longint v);
    if (v > 8388607) return 8388607;
    if (v < -8388608) return -8388608;
    return v;
  endfunction

  // solve L0 = L+C+LS and R0 = R+C+RS for the channels not carried on T2..T4 (R4)
  task automatic derive(input int m, input int x[5], output int w[5]);
    int car[3];
    bit kn[5];
    case (m)
      0: car = '{2, 3, 4};
      1: car = '{0, 3, 4};
      2: car = '{1, 3, 4};
      3: car = '{0, 1, 3};
      4: car = '{2, 0, 4};
      5: car = '{2, 3, 1};
      6: car = '{2, 0, 1};
      default: car = '{0, 1, 2};
    endcase
    for (int i = 0; i < 5; i++) begin w[i] = 0; kn[i] = 0; end
    for (int k = 0; k < 3; k++) begin w[car[k]] = x[2+k]; kn[car[k]] = 1; end
    for (int pass = 0; pass < 2; pass++)
      for (int e = 0; e < 2; e++) begin
        int mem[3];
        int nu, u, acc;
        if (e == 0) mem = '{0, 2, 3}; else mem = '{1, 2, 4};
        nu = 0; u = 0; acc = x[e];
        for (int j = 0; j < 3; j++)
          if (!kn[mem[j]]) begin nu++; u = mem[j]; end
          else acc -= w[mem[j]];
        if (nu == 1) begin w[u] = acc; kn[u] = 1; end
      end
  endtask

  function automatic longint expect_out(int m, int smp, int ch);
    longint a, p;
    a = 0;
    for (int t = 0; t < 5; t++) a = sat24(a + longint'(cf[m][ch][t]) * tv[t][smp]);
    p = a * gv[ch];
    return sat24((p + (64'sd1 <<< 21)) >>> 22);
  endfunction

  task automatic push1(input int sel, input int val);
    push = 1'b1; push_sel = 3'(sel); push_data = 24'(val);
    @(negedge clk);
    push = 1'b0;
  endtask

  task automatic fill(input bit skip_last);
    for (int s = 0; s < 3; s++)
      for (int t = 0; t < 5; t++)
        if (!(skip_last && s == 2 && t == 4)) push1(t, tv[t][s]);
  endtask

  task automatic run(input int m, input bit disturb);
    int n, nd, kd;
    mode = 3'(m);
    for (int c = 0; c < 5; c++) gain[c*24 +: 24] = 24'(gv[c]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0; nd = 0; kd = 0;
    for (int k = 1; k <= 95; k++) begin
      if (out_valid) begin
        chk("R7 chan", out_chan == 3'(n % 5), out_chan, n % 5);
        chk("R8 slot", k == 7 + 5*n, k, 7 + 5*n);
        chk("R5 R6 data", $signed(out_data) == expect_out(m, n / 5, n % 5),
            $signed(out_data), expect_out(m, n / 5, n % 5));
        n++;
      end
      if (done) begin nd++; kd = k; end
      if (disturb && k == 20) start = 1'b1;
      if (disturb && k == 21) start = 1'b0;
      if (disturb && k == 30) begin push = 1'b1; push_sel = 3'd0; push_data = 24'd12345; end
      if (disturb && k == 31) push = 1'b0;
      @(negedge clk);
    end
    chk(disturb ? "R10 count" : "R7 count", n == 15, n, 15);
    chk("R9 done", nd == 1 && kd == 78, kd, 78);
  endtask

  initial begin
    rst_n = 1'b0; push = 1'b0; push_sel = '0; push_data = '0; start = 1'b0; mode = '0; gain = '0;
    for (int m = 0; m < 8; m++)
      for (int t = 0; t < 5; t++) begin
        int x[5], w[5];
        for (int i = 0; i < 5; i++) x[i] = (i == t) ? 1 : 0;
        derive(m, x, w);
        for (int c = 0; c < 5; c++) cf[m][c][t] = w[c];
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid", out_valid == 1'b0, out_valid, 0);
    chk("R1 done", done == 1'b0, done, 0);

    // R1 R3: empty FIFOs, start ignored
    start = 1'b1; @(negedge clk); start = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin if (out_valid) seen++; @(negedge clk); end
      chk("R1 empty start", seen == 0, seen, 0);
    end

    // R2 R3: partial fill ignored, extra pushes ignored
    for (int s = 0; s < 3; s++) for (int t = 0; t < 5; t++) tv[t][s] = rnd24() / 4;
    for (int c = 0; c < 5; c++) gv[c] = 4194304 - c * 100000;
    fill(1'b1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin if (out_valid) seen++; @(negedge clk); end
      chk("R3 partial start", seen == 0, seen, 0);
    end
    push1(0, 999);
    push1(5, 777);
    push1(7, 555);
    push1(4, tv[4][2]);
    run(2, 1'b0);

    // R4 R5 R6: sweep every mode over three patterns
    for (int pat = 0; pat < 3; pat++)
      for (int m = 0; m < 8; m++) begin
        for (int s = 0; s < 3; s++)
          for (int t = 0; t < 5; t++)
            tv[t][s] = (pat == 0) ? (rnd24() % 1000) : rnd24();
        for (int c = 0; c < 5; c++)
          gv[c] = (pat == 2) ? rnd24() : (4194304 + rnd24() / 16);
        fill(1'b0);
        run(m, 1'b0);
      end

    // R5 R6: saturation in the sum and in the product (mode 2)
    tv[0][0] = 8388607;  tv[1][0] = -8388608; tv[2][0] = 8388607; tv[3][0] = -8388608; tv[4][0] = 8388607;
    tv[0][1] = -8388608; tv[1][1] = 8388607;  tv[2][1] = -8388608; tv[3][1] = 8388607; tv[4][1] = -8388608;
    tv[0][2] = 6000000;  tv[1][2] = -6000000; tv[2][2] = 100;      tv[3][2] = -3000000; tv[4][2] = 7;
    gv[0] = 8388607; gv[1] = -8388608; gv[2] = 4194304; gv[3] = 1; gv[4] = -1;
    fill(1'b0);
    run(2, 1'b0);

    // R10 R2: start and push while busy have no effect
    for (int s = 0; s < 3; s++) for (int t = 0; t < 5; t++) tv[t][s] = rnd24() / 2;
    for (int c = 0; c < 5; c++) gv[c] = rnd24();
    fill(1'b0);
    run(6, 1'b1);
    for (int s = 0; s < 3; s++) for (int t = 0; t < 5; t++) tv[t][s] = rnd24() / 3;
    fill(1'b0);
    run(3, 1'b0);

    summary();
    $finish;
  end
endmodule